// File: doc/BRIEF.md
# Parallel Bus Master Controller

This block lets a processor reach byte-wide devices on an external parallel bus. The host starts a transfer by touching a low data register. A read access starts a bus read. A write access stores the byte and starts a bus write. The controller then presents the address and an optional chip-select. It produces either separate read and write strobes or a single enable strobe with a direction line. Each strobe is framed by programmable setup, width and hold wait states. In wide mode one host access becomes two back-to-back byte cycles. The address can step up or down after each finished operation. A BUSY output and a completion interrupt report progress.

The read path is pipelined. The value the host sees in the low data register when it starts a read is the result of the previous bus read. The first read after reset is therefore a dummy.

The sequencer has four states. PH_IDLE waits for a host access. PH_BEGIN is the setup phase. PH_MIDDLE is the strobe phase. PH_END is the hold phase. The transitions are:

- start: PH_IDLE to the first phase.
- setup done: PH_BEGIN to PH_MIDDLE.
- strobe done: PH_MIDDLE to PH_END when a hold phase is configured.
- byte done: from the last phase of a byte, either re-entry to the first phase for the high byte, or re-entry for a new back-to-back access, or return to PH_IDLE.

The first phase is PH_BEGIN when the setup count is non-zero, and PH_MIDDLE otherwise.

Top module: `pmb_ctrl`

## Requirements
- R1: After reset, busy, irq, every strobe, the direction line and bus_doe are 0, and bus_addr is 0.
- R2: An access on host_rd_lo starts a bus read. host_rdata_lo at that moment still holds the byte captured by the previous bus read, and holds 0 after reset. After the operation, host_rdata_lo holds the newly read byte.
- R3: With cfg_wait_m non-zero, an operation spends cfg_wait_b setup cycles, then cfg_wait_m strobe cycles, then cfg_wait_e hold cycles. The first strobe cycle is cycle cfg_wait_b+1 after the access is accepted. Read data is captured in the last strobe cycle.
- R4: With cfg_wait_m = 0, each byte takes exactly one strobe cycle, and cfg_wait_b and cfg_wait_e have no effect.
- R5: busy is 1 in every cycle of an operation except the last one, so a one-cycle operation never raises busy.
- R6: A host access to the low register while busy is 1 starts no bus cycle, and its write byte is not stored.
- R7: A host access made in the last cycle of an operation, when busy is 0, is accepted and starts the next operation on the following cycle.
- R8: With cfg_wide = 1, a read performs two byte cycles. The first byte goes to host_rdata_lo and the second to host_rdata_hi.
- R9: With cfg_wide = 1, a write drives the low data byte during the first byte cycle and the byte stored through host_wr_hi during the second.
- R10: cfg_step selects the address change applied once at the end of each operation, including wide ones: 00 hold, 01 add one, 10 subtract one, 11 hold. addr_ld loads the address.
- R11: When the chip-select function is on, the two top address bits are untouched by stepping, and the lower bits wrap on their own. When it is off, stepping carries into and borrows from the full address.
- R12: cfg_cs_fn selects what bus_addr bit ADDR_W-2 carries. With 00 or 11 it is an address bit. With 01 it is a chip-select that is 1 during every cycle of an operation and 0 when idle. With 10 it is a chip-select that is 0 during an operation and 1 when idle.
- R13: With cfg_strobe_mode = 0, bus_rd or bus_wr strobes in the strobe phase, and bus_en and bus_dir stay 0. With cfg_strobe_mode = 1, only bus_en strobes, and bus_dir is 1 throughout a read and 0 throughout a write.
- R14: With cfg_irq_en = 1, irq is a one-cycle pulse in the cycle after the last cycle of each operation. With cfg_irq_en = 0, irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd_lo | input | 1 | Host read of the low data register (starts a bus read) |
| host_wr_lo | input | 1 | Host write of the low data register (starts a bus write) |
| host_wr_hi | input | 1 | Host write of the high data register |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata_lo | output | DATA_W | Low read data register |
| host_rdata_hi | output | DATA_W | High read data register |
| cfg_wide | input | 1 | Two byte cycles per access |
| cfg_strobe_mode | input | 1 | 0 = separate read/write strobes, 1 = enable plus direction |
| cfg_step | input | 2 | Address step mode |
| cfg_cs_fn | input | 2 | Chip-select function of address bit ADDR_W-2 |
| cfg_wait_b | input | WB_W | Setup wait cycles |
| cfg_wait_m | input | WM_W | Strobe width in cycles |
| cfg_wait_e | input | WE_W | Hold wait cycles |
| cfg_irq_en | input | 1 | Interrupt enable |
| addr_ld | input | 1 | Load the address register |
| addr_ld_val | input | ADDR_W | Address load value |
| bus_addr | output | ADDR_W | Bus address with chip-select overlay |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_en | output | 1 | Enable strobe |
| bus_dir | output | 1 | Direction, 1 = read |
| busy | output | 1 | Operation in progress, not in its last cycle |
| irq | output | 1 | Completion pulse |

## Verification
The assertions assume that the cfg_* inputs stay constant while an operation runs. They also assume that host_rd_lo and host_wr_lo are never raised together, and that addr_ld is pulsed only while the block is idle. The directed tasks change configuration and load the address only after a full observation window, by which time every operation has finished. They raise exactly one host access per request, with two exceptions: the ignore and back-to-back scenarios, where a single extra write is placed on purpose inside a running operation or in its last cycle.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BEGIN  = 2'd1,
        PH_MIDDLE = 2'd2,
        PH_END    = 2'd3
    } pmb_phase_e;

    localparam logic [1:0] STEP_INC = 2'b01;
    localparam logic [1:0] STEP_DEC = 2'b10;

    localparam logic [1:0] CSF_HIGH = 2'b01;
    localparam logic [1:0] CSF_LOW  = 2'b10;
endpackage

// File: rtl/pmb_phase_fsm.sv
module pmb_phase_fsm
    import pmb_pkg::*;
#(
    parameter int WB_W = 2,
    parameter int WM_W = 4,
    parameter int WE_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_rd,
    input  logic            req_wr,
    input  logic            cfg_wide,
    input  logic [WB_W-1:0] cfg_wait_b,
    input  logic [WM_W-1:0] cfg_wait_m,
    input  logic [WE_W-1:0] cfg_wait_e,
    output pmb_phase_e      phase,
    output logic            byte_hi,
    output logic            op_rd,
    output logic            busy,
    output logic            done,
    output logic            accept,
    output logic            sample
);
    localparam int MBE_W = (WB_W > WE_W) ? WB_W : WE_W;
    localparam int CNT_W = (WM_W > MBE_W) ? WM_W : MBE_W;

    pmb_phase_e       nxt;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             hi_n, rd_n;
    pmb_phase_e       f_ph;
    logic [CNT_W-1:0] f_cnt;
    logic             last_cnt, byte_end, more;

    // Entry phase of a byte cycle
    always_comb begin
        if (cfg_wait_m == '0) begin
            f_ph  = PH_MIDDLE;
            f_cnt = '0;
        end else if (cfg_wait_b != '0) begin
            f_ph  = PH_BEGIN;
            f_cnt = CNT_W'(cfg_wait_b) - CNT_W'(1);
        end else begin
            f_ph  = PH_MIDDLE;
            f_cnt = CNT_W'(cfg_wait_m) - CNT_W'(1);
        end
    end

    // Status outputs
    always_comb begin
        last_cnt = (cnt == '0);
        byte_end = last_cnt &&
                   ((phase == PH_MIDDLE && (cfg_wait_m == '0 || cfg_wait_e == '0)) ||
                    phase == PH_END);
        more     = cfg_wide && !byte_hi;
        done     = byte_end && !more;
        busy     = (phase != PH_IDLE) && !done;
        accept   = (req_rd || req_wr) && !busy;
        sample   = (phase == PH_MIDDLE) && last_cnt;
    end

    // Next-state logic
    always_comb begin
        nxt   = phase;
        cnt_n = cnt;
        hi_n  = byte_hi;
        rd_n  = op_rd;
        unique case (phase)
            PH_IDLE: begin
                if (accept) begin
                    nxt   = f_ph;
                    cnt_n = f_cnt;
                    hi_n  = 1'b0;
                    rd_n  = req_rd;
                end
            end
            PH_BEGIN: begin
                if (last_cnt) begin
                    nxt   = PH_MIDDLE;
                    cnt_n = CNT_W'(cfg_wait_m) - CNT_W'(1);
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            PH_MIDDLE, PH_END: begin
                if (!last_cnt) begin
                    cnt_n = cnt - CNT_W'(1);
                end else if (phase == PH_MIDDLE && !byte_end) begin
                    nxt   = PH_END;
                    cnt_n = CNT_W'(cfg_wait_e) - CNT_W'(1);
                end else if (more) begin
                    nxt   = f_ph;
                    cnt_n = f_cnt;
                    hi_n  = 1'b1;
                end else if (accept) begin
                    nxt   = f_ph;
                    cnt_n = f_cnt;
                    hi_n  = 1'b0;
                    rd_n  = req_rd;
                end else begin
                    nxt   = PH_IDLE;
                    hi_n  = 1'b0;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            byte_hi <= 1'b0;
            op_rd   <= 1'b0;
        end else begin
            phase   <= nxt;
            cnt     <= cnt_n;
            byte_hi <= hi_n;
            op_rd   <= rd_n;
        end
    end

    assert_busy_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (phase != PH_IDLE));

    assert_dir_held_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_rd));

    assert_zero_width_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_wait_m == '0 && !cfg_wide) |=> done);
endmodule

// File: rtl/pmb_addr_gen.sv
module pmb_addr_gen
    import pmb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              upd,
    input  logic [1:0]        step,
    input  logic [1:0]        cs_fn,
    input  logic              active,
    output logic [ADDR_W-1:0] bus_addr
);
    localparam int LOW_W  = ADDR_W - 2;
    localparam int CS_BIT = ADDR_W - 2;

    logic [ADDR_W-1:0] addr, stepped;
    logic              cs_on;

    always_comb begin
        cs_on   = (cs_fn == CSF_HIGH) || (cs_fn == CSF_LOW);
        stepped = addr;
        if (step == STEP_INC) begin
            if (cs_on) stepped = {addr[ADDR_W-1:LOW_W], addr[LOW_W-1:0] + LOW_W'(1)};
            else       stepped = addr + ADDR_W'(1);
        end else if (step == STEP_DEC) begin
            if (cs_on) stepped = {addr[ADDR_W-1:LOW_W], addr[LOW_W-1:0] - LOW_W'(1)};
            else       stepped = addr - ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   addr <= '0;
        else if (ld)  addr <= ld_val;
        else if (upd) addr <= stepped;
    end

    always_comb begin
        bus_addr = addr;
        if (cs_on) bus_addr[CS_BIT] = (cs_fn == CSF_HIGH) ? active : !active;
    end

    assert_top_bits_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_on && upd && !ld) |=> (addr[ADDR_W-1:LOW_W] == $past(addr[ADDR_W-1:LOW_W])));

    assert_addr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !ld) |=> $stable(addr));
endmodule

// File: rtl/pmb_data.sv
module pmb_data
    import pmb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cap,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              sample,
    input  logic              byte_hi,
    input  logic              op_rd,
    input  pmb_phase_e        phase,
    input  logic              done,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              strobe_mode,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rd_lo,
    output logic [DATA_W-1:0] rd_hi,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              strb_rd,
    output logic              strb_wr,
    output logic              strb_en,
    output logic              strb_dir,
    output logic              irq
);
    logic [DATA_W-1:0] wr_lo, wr_hi;
    logic              act, mid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_lo <= '0;
            wr_hi <= '0;
            rd_lo <= '0;
            rd_hi <= '0;
            irq   <= 1'b0;
        end else begin
            if (wr_cap) wr_lo <= host_wdata;
            if (hi_wr)  wr_hi <= host_wdata;
            if (sample && op_rd) begin
                if (byte_hi) rd_hi <= bus_din;
                else         rd_lo <= bus_din;
            end
            irq <= done && irq_en;
        end
    end

    always_comb begin
        act      = (phase != PH_IDLE);
        mid      = (phase == PH_MIDDLE);
        strb_rd  = !strobe_mode && mid && op_rd;
        strb_wr  = !strobe_mode && mid && !op_rd;
        strb_en  = strobe_mode && mid;
        strb_dir = strobe_mode && act && op_rd;
        bus_doe  = act && !op_rd;
        bus_dout = byte_hi ? wr_hi : wr_lo;
    end

    assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strb_rd, strb_wr, strb_en}));
endmodule

// File: rtl/pmb_ctrl.sv
module pmb_ctrl
    import pmb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WB_W   = 2,
    parameter int WM_W   = 4,
    parameter int WE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_lo,
    input  logic              host_wr_lo,
    input  logic              host_wr_hi,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata_lo,
    output logic [DATA_W-1:0] host_rdata_hi,
    input  logic              cfg_wide,
    input  logic              cfg_strobe_mode,
    input  logic [1:0]        cfg_step,
    input  logic [1:0]        cfg_cs_fn,
    input  logic [WB_W-1:0]   cfg_wait_b,
    input  logic [WM_W-1:0]   cfg_wait_m,
    input  logic [WE_W-1:0]   cfg_wait_e,
    input  logic              cfg_irq_en,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_ld_val,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_en,
    output logic              bus_dir,
    output logic              busy,
    output logic              irq
);
    pmb_phase_e phase;
    logic       byte_hi, op_rd, done, accept, sample, wr_cap;

    pmb_phase_fsm #(.WB_W(WB_W), .WM_W(WM_W), .WE_W(WE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_rd(host_rd_lo), .req_wr(host_wr_lo),
        .cfg_wide(cfg_wide), .cfg_wait_b(cfg_wait_b),
        .cfg_wait_m(cfg_wait_m), .cfg_wait_e(cfg_wait_e),
        .phase(phase), .byte_hi(byte_hi), .op_rd(op_rd),
        .busy(busy), .done(done), .accept(accept), .sample(sample)
    );

    assign wr_cap = accept && !host_rd_lo;

    pmb_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .ld(addr_ld), .ld_val(addr_ld_val), .upd(done),
        .step(cfg_step), .cs_fn(cfg_cs_fn),
        .active(phase != PH_IDLE), .bus_addr(bus_addr)
    );

    pmb_data #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n),
        .wr_cap(wr_cap), .hi_wr(host_wr_hi), .host_wdata(host_wdata),
        .sample(sample), .byte_hi(byte_hi), .op_rd(op_rd), .phase(phase),
        .done(done), .bus_din(bus_din), .strobe_mode(cfg_strobe_mode),
        .irq_en(cfg_irq_en),
        .rd_lo(host_rdata_lo), .rd_hi(host_rdata_hi),
        .bus_dout(bus_dout), .bus_doe(bus_doe),
        .strb_rd(bus_rd), .strb_wr(bus_wr), .strb_en(bus_en),
        .strb_dir(bus_dir), .irq(irq)
    );

    assert_irq_follows_end_R14: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(phase) != PH_IDLE));
endmodule

// File: tb/sim_pmb_ctrl.sv
module sim_pmb_ctrl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        host_rd_lo = 0, host_wr_lo = 0, host_wr_hi = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata_lo, host_rdata_hi;
    logic        cfg_wide = 0, cfg_strobe_mode = 0, cfg_irq_en = 0;
    logic [1:0]  cfg_step = 0, cfg_cs_fn = 0;
    logic [1:0]  cfg_wait_b = 0, cfg_wait_e = 0;
    logic [3:0]  cfg_wait_m = 0;
    logic        addr_ld = 0;
    logic [15:0] addr_ld_val = 0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout, bus_din;
    logic        bus_doe, bus_rd, bus_wr, bus_en, bus_dir, busy, irq;

    pmb_ctrl u0 (.*);

    // Bus device: returns 0x40 plus the number of finished read strobes
    logic [7:0] rd_cnt = 0;
    logic       prev_rs = 0;
    wire        rs = bus_rd | (bus_en & bus_dir);
    assign bus_din = 8'h40 + rd_cnt;
    always @(negedge clk) begin
        if (prev_rs && !rs) rd_cnt <= rd_cnt + 8'd1;
        prev_rs <= rs;
    end

    int errs = 0, checks = 0;
    int n_busy, n_strb, first_strb, n_pulse, n_cs, n_irq, n_dir, n_sep;
    int rd_pulses = 0, p_first;
    logic [7:0] dbuf [2];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // inj: 0 none, 1 extra write in cycle 1, 2 extra write in the last cycle
    task automatic run_op(input bit rd, input logic [7:0] wd, input int inj, input logic [7:0] inj_d);
        bit prev_s = 0, injected = 0, s;
        n_busy = 0; n_strb = 0; first_strb = 0; n_pulse = 0;
        n_cs = 0; n_irq = 0; n_dir = 0; n_sep = 0;
        dbuf[0] = 0; dbuf[1] = 0;
        p_first = rd_pulses;
        @(negedge clk);
        host_rd_lo = rd; host_wr_lo = !rd; host_wdata = wd;
        for (int k = 1; k <= 48; k++) begin
            @(negedge clk);
            host_rd_lo = 0; host_wr_lo = 0;
            s = bus_rd | bus_wr | bus_en;
            if (busy) n_busy++;
            if (s) begin
                n_strb++;
                if (first_strb == 0) first_strb = k;
            end
            if (s && !prev_s) begin
                if (n_pulse < 2) dbuf[n_pulse] = bus_dout;
                n_pulse++;
                if (rs) rd_pulses++;
            end
            prev_s = s;
            if (cfg_cs_fn == 2'b01 && bus_addr[14])  n_cs++;
            if (cfg_cs_fn == 2'b10 && !bus_addr[14]) n_cs++;
            if (irq) n_irq++;
            if (bus_en && bus_dir) n_dir++;
            if (bus_rd || bus_wr) n_sep++;
            if (inj == 1 && k == 1) begin
                host_wr_lo = 1; host_wdata = inj_d;
            end
            if (inj == 2 && !injected && !busy) begin
                host_wr_lo = 1; host_wdata = inj_d; injected = 1;
            end
        end
    endtask

    task automatic set_wait(input logic [1:0] b, input logic [3:0] m, input logic [1:0] e);
        cfg_wait_b = b; cfg_wait_m = m; cfg_wait_e = e;
    endtask

    task automatic load_addr(input logic [15:0] v);
        @(negedge clk); addr_ld = 1; addr_ld_val = v;
        @(negedge clk); addr_ld = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {bus_rd, bus_wr, bus_en, bus_dir}, 0);
        chk("R1 irq", irq, 0);
        chk("R1 addr", bus_addr, 0);
        chk("R1 doe", bus_doe, 0);
    endtask

    task automatic t_pipeline();
        int pa;
        set_wait(0, 1, 0);
        chk("R2 dummy value", host_rdata_lo, 8'h00);
        run_op(1, 0, 0, 0);
        pa = p_first;
        chk("R2 first capture", host_rdata_lo, 8'(8'h40 + pa));
        chk("R2 value at next access", host_rdata_lo, 8'(8'h40 + pa));
        run_op(1, 0, 0, 0);
        chk("R2 second capture", host_rdata_lo, 8'(8'h40 + p_first));
    endtask

    task automatic t_waits();
        cfg_cs_fn = 2'b01; cfg_irq_en = 1;
        set_wait(2, 3, 1);
        run_op(0, 8'h5A, 0, 0);
        chk("R3 first strobe cycle", first_strb, 3);
        chk("R3 strobe width", n_strb, 3);
        chk("R12 cs active-high span", n_cs, 6);
        chk("R5 busy cycles", n_busy, 5);
        chk("R3 write data", dbuf[0], 8'h5A);
        chk("R14 irq pulses", n_irq, 1);
    endtask

    task automatic t_zero_mid();
        set_wait(3, 0, 3);
        run_op(0, 8'h77, 0, 0);
        chk("R4 single strobe", n_strb, 1);
        chk("R4 strobe at cycle 1", first_strb, 1);
        chk("R4 cs span", n_cs, 1);
        chk("R5 no busy on single cycle", n_busy, 0);
    endtask

    task automatic t_cs_low();
        cfg_cs_fn = 2'b10;
        set_wait(1, 1, 1);
        run_op(0, 8'h01, 0, 0);
        chk("R12 cs active-low span", n_cs, 3);
        chk("R12 cs idle level", bus_addr[14], 1);
        cfg_cs_fn = 2'b00;
    endtask

    task automatic t_ignore();
        set_wait(1, 2, 1);
        run_op(0, 8'h33, 1, 8'hEE);
        chk("R6 one strobe only", n_pulse, 1);
        chk("R6 data not replaced", dbuf[0], 8'h33);
        chk("R5 busy cycles", n_busy, 3);
    endtask

    task automatic t_b2b();
        cfg_irq_en = 1;
        set_wait(0, 1, 1);
        run_op(0, 8'h11, 2, 8'h22);
        chk("R7 two strobes", n_pulse, 2);
        chk("R7 first data", dbuf[0], 8'h11);
        chk("R7 second data", dbuf[1], 8'h22);
        chk("R14 two irq pulses", n_irq, 2);
    endtask

    task automatic t_wide();
        cfg_wide = 1;
        set_wait(0, 1, 1);
        run_op(1, 0, 0, 0);
        chk("R8 two read strobes", n_pulse, 2);
        chk("R8 low byte", host_rdata_lo, 8'(8'h40 + p_first));
        chk("R8 high byte", host_rdata_hi, 8'(8'h40 + p_first + 1));
        @(negedge clk); host_wr_hi = 1; host_wdata = 8'hB2;
        @(negedge clk); host_wr_hi = 0;
        run_op(0, 8'hA1, 0, 0);
        chk("R9 low byte first", dbuf[0], 8'hA1);
        chk("R9 high byte second", dbuf[1], 8'hB2);
        chk("R5 busy wide", n_busy, 3);
        cfg_wide = 0;
    endtask

    task automatic t_addr();
        cfg_cs_fn = 2'b00;
        set_wait(0, 0, 0);
        load_addr(16'h00FE);
        cfg_step = 2'b01;
        run_op(0, 0, 0, 0);
        run_op(0, 0, 0, 0);
        chk("R10 increment", bus_addr, 16'h0100);
        cfg_wide = 1;
        run_op(0, 0, 0, 0);
        chk("R10 once per wide op", bus_addr, 16'h0101);
        cfg_wide = 0;
        cfg_step = 2'b10;
        run_op(0, 0, 0, 0);
        chk("R10 decrement", bus_addr, 16'h0100);
        cfg_step = 2'b00;
        run_op(0, 0, 0, 0);
        chk("R10 hold", bus_addr, 16'h0100);
        cfg_step = 2'b01;
        load_addr(16'h3FFF);
        run_op(0, 0, 0, 0);
        chk("R11 full carry", bus_addr, 16'h4000);
        cfg_cs_fn = 2'b01;
        load_addr(16'hBFFF);
        run_op(0, 0, 0, 0);
        chk("R11 top bits kept on inc", bus_addr, 16'h8000);
        cfg_step = 2'b10;
        run_op(0, 0, 0, 0);
        chk("R11 top bits kept on dec", bus_addr, 16'hBFFF);
        cfg_step = 2'b00; cfg_cs_fn = 2'b00;
    endtask

    task automatic t_enable_mode();
        cfg_strobe_mode = 1;
        set_wait(0, 2, 0);
        run_op(1, 0, 0, 0);
        chk("R13 no separate strobes", n_sep, 0);
        chk("R13 enable width", n_strb, 2);
        chk("R13 dir read", n_dir, 2);
        run_op(0, 8'h09, 0, 0);
        chk("R13 dir write", n_dir, 0);
        chk("R13 enable on write", n_strb, 2);
        cfg_strobe_mode = 0;
    endtask

    task automatic t_irq_off();
        cfg_irq_en = 0;
        set_wait(1, 1, 0);
        run_op(0, 8'h44, 0, 0);
        chk("R14 irq disabled", n_irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pipeline();
        t_waits();
        t_zero_mid();
        t_cs_low();
        t_ignore();
        t_b2b();
        t_wide();
        t_addr();
        t_enable_mode();
        t_irq_off();
        finish_run();
    end
endmodule